// File: doc/BRIEF.md
# Two-Phase Supervisory Watchdog

This block supervises software progress with a countdown that is advanced by a programmable clock divider. If software fails to rewrite the configuration word before the countdown runs out, the block first raises a one-cycle interrupt and reloads the countdown with a separate grace value. If that grace count also runs out, it raises a one-cycle system reset request and returns to its power-up values. The interrupt controller and the reset distribution that consume these pulses sit outside the block.

Software services the watchdog by writing the configuration word again, which reloads every field, cancels a pending grace phase and starts counting anew. Software that does not want supervision can disable the block through a separate one-shot disable strobe. That strobe is honoured only while the block is still in its untouched power-up state, so runaway code cannot switch off supervision once it has been armed. Both write inputs are plain single-cycle strobes with no back-pressure: the block accepts a strobe on every cycle in which it is high.

Top module: `twostage_watchdog`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, irq_o and sys_rst_req_o are low.
- R2: The configuration word packs the countdown in bits [CNT_W-1:0], the divider value in the next PRE_W bits and the grace value in the top DLY_W bits (bits 15:0, 23:16 and 31:24 at the defaults). After reset all three hold all-ones and the block counts in its power-up state without any write.
- R3: With divider value P, the countdown advances once every P+1 clocks. With countdown C written at clock edge E, irq_o is high in the cycle after edge E+(C+1)(P+1).
- R4: When the countdown is zero at an advance in the first phase, irq_o pulses for exactly one cycle, the countdown loads the grace value and the grace phase starts.
- R5: A disable strobe (dis_we) in the power-up state stops all counting, so neither output pulses until the next configuration write. A disable strobe in any other state has no effect on the timing of either output.
- R6: With grace value D, sys_rst_req_o pulses for exactly one cycle (D+1)(P+1) clocks after the interrupt pulse. It never pulses in the same cycle as irq_o.
- R7: After the reset request pulse, the block is back in its power-up state with all-ones fields, counts again and accepts a disable strobe.
- R8: A configuration write (cfg_we) loads all three fields, restarts the divider, cancels a pending grace phase and leaves the block enabled from any state, including the stopped one. It takes priority over a disable strobe in the same cycle.
- R9: A disabled block moves to its stopped state at its next divider advance and stays stopped, with both outputs low, until a configuration write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | CNT_W+PRE_W+DLY_W | Configuration word (countdown, divider, grace value) |
| dis_we | input | 1 | Disable strobe, honoured only in the power-up state |
| irq_o | output | 1 | One-cycle expiry interrupt pulse |
| sys_rst_req_o | output | 1 | One-cycle system reset request pulse |

## Verification
Every internal fault of this block shows up only as the timing of the two pulses. A divider that slips a count moves the interrupt by C+1 cycles, and a countdown off by one moves it by P+1 cycles. A grace phase that is not entered or not cleared turns an interrupt into a reset request or the reverse. A state machine that honours a late disable strobe, or that fails to restore defaults, shows as a pulse that is missing or mistimed within one full expiry period. The bench therefore runs a small configuration through every divider and countdown value and several grace values, and it checks the exact cycle of each pulse against (C+1)(P+1) and (D+1)(P+1).

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    WD_INIT = 2'd0,
    WD_OFF  = 2'd1,
    WD_RUN  = 2'd2,
    WD_HALT = 2'd3
  } wd_state_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restore,
  input  logic             run,
  input  logic             load,
  input  logic [PRE_W-1:0] load_val,
  output logic             tick
);
  localparam logic [PRE_W-1:0] PRE_DEFAULT = '1;

  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] cnt_q;

  assign tick = run && !load && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || restore) begin
      div_q <= PRE_DEFAULT;
      cnt_q <= PRE_DEFAULT;
    end else if (load) begin
      div_q <= load_val;
      cnt_q <= load_val;
    end else if (run) begin
      if (cnt_q == '0) cnt_q <= div_q;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= div_q);  // R3

  AST_PRE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_q != '0) |=> !tick);  // R3
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 16,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restore,
  input  logic             load,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic [DLY_W-1:0] load_dly,
  input  logic             tick,
  output logic             hit_irq,
  output logic             hit_rst
);
  localparam logic [CNT_W-1:0] CNT_DEFAULT = '1;
  localparam logic [DLY_W-1:0] DLY_DEFAULT = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [DLY_W-1:0] dly_q;
  logic             pend_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign hit_irq = tick && !load && at_zero && !pend_q;
  assign hit_rst = tick && !load && at_zero &&  pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restore) begin
      cnt_q  <= CNT_DEFAULT;
      dly_q  <= DLY_DEFAULT;
      pend_q <= 1'b0;
    end else if (load) begin
      cnt_q  <= load_cnt;
      dly_q  <= load_dly;
      pend_q <= 1'b0;
    end else if (tick) begin
      if (!at_zero) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (!pend_q) begin
        cnt_q  <= CNT_W'(dly_q);
        pend_q <= 1'b1;
      end
    end
  end

  AST_PEND_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> ($past(cnt_q) == '0 && $past(tick)));  // R4

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !restore && !(tick && at_zero)) |=>
      (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 1'b1));  // R3

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !restore) |=> !pend_q);  // R8
endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
  import wdt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic dis_we,
  input  logic pre_tick,
  input  logic hit_irq,
  input  logic hit_rst,
  output logic pre_run,
  output logic cnt_tick,
  output logic restore,
  output logic irq_q,
  output logic rst_q
);
  wd_state_e state_q;
  wd_state_e state_d;

  assign pre_run  = (state_q != WD_HALT);
  assign cnt_tick = pre_tick && (state_q == WD_INIT || state_q == WD_RUN);
  assign restore  = hit_rst;

  always_comb begin
    state_d = state_q;
    if (hit_rst)
      state_d = WD_INIT;
    else if (cfg_we)
      state_d = WD_RUN;
    else if (dis_we && state_q == WD_INIT)
      state_d = WD_OFF;
    else if (state_q == WD_OFF && pre_tick)
      state_d = WD_HALT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WD_INIT;
      irq_q   <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= hit_irq;
      rst_q   <= hit_rst;
    end
  end

  AST_DIS_LATE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WD_RUN && dis_we && !cfg_we && !hit_rst) |=> state_q == WD_RUN);  // R5

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WD_HALT && !cfg_we) |=> state_q == WD_HALT);  // R9

  AST_CFG_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !hit_rst) |=> state_q == WD_RUN);  // R8

  AST_RESTORE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    hit_rst |=> (state_q == WD_INIT && rst_q));  // R7

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WD_OFF || state_q == WD_HALT) |-> !hit_irq && !hit_rst);  // R5
endmodule

// File: rtl/twostage_watchdog.sv
module twostage_watchdog #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8,
  parameter int DLY_W = 8,
  localparam int CFG_W = CNT_W + PRE_W + DLY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             dis_we,
  output logic             irq_o,
  output logic             sys_rst_req_o
);
  localparam int PRE_LSB = CNT_W;
  localparam int DLY_LSB = CNT_W + PRE_W;

  logic [CNT_W-1:0] f_cnt;
  logic [PRE_W-1:0] f_pre;
  logic [DLY_W-1:0] f_dly;
  logic pre_tick, pre_run, cnt_tick, restore, hit_irq, hit_rst;

  assign f_cnt = cfg_wdata[CNT_W-1:0];
  assign f_pre = cfg_wdata[PRE_LSB +: PRE_W];
  assign f_dly = cfg_wdata[DLY_LSB +: DLY_W];

  wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restore(restore), .run(pre_run),
    .load(cfg_we), .load_val(f_pre), .tick(pre_tick)
  );

  wdt_counter #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restore(restore), .load(cfg_we),
    .load_cnt(f_cnt), .load_dly(f_dly), .tick(cnt_tick),
    .hit_irq(hit_irq), .hit_rst(hit_rst)
  );

  wdt_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .dis_we(dis_we),
    .pre_tick(pre_tick), .hit_irq(hit_irq), .hit_rst(hit_rst),
    .pre_run(pre_run), .cnt_tick(cnt_tick), .restore(restore),
    .irq_q(irq_o), .rst_q(sys_rst_req_o)
  );

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);  // R4

  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req_o |=> !sys_rst_req_o);  // R6

  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_o && sys_rst_req_o));  // R6

  AST_OUT_AFTER_RESET: assert property (@(posedge clk)
    !$past(rst_n) |-> (!irq_o && !sys_rst_req_o));  // R1
endmodule

// File: tb/twostage_watchdog_bench.sv
module twostage_watchdog_bench;
  localparam int CW = 4;
  localparam int PW = 2;
  localparam int DW = 3;
  localparam int FW = CW + PW + DW;
  localparam int DEF_IRQ = (2**CW) * (2**PW);
  localparam int DEF_RST = (2**DW) * (2**PW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [FW-1:0] cfg_wdata = '0;
  logic dis_we = 1'b0;
  logic irq_o, sys_rst_req_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  twostage_watchdog #(.CNT_W(CW), .PRE_W(PW), .DLY_W(DW)) u_twostage_watchdog (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .dis_we(dis_we), .irq_o(irq_o), .sys_rst_req_o(sys_rst_req_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  task automatic wr_cfg(input int c, input int p, input int d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = {DW'(d), PW'(p), CW'(c)};
    @(posedge clk);
    #1 cfg_we = 1'b0;
  endtask

  task automatic dis_pulse();
    @(negedge clk);
    dis_we = 1'b1;
    @(posedge clk);
    #1 dis_we = 1'b0;
  endtask

  // sel 0 waits for irq_o, sel 1 for sys_rst_req_o; other counts pulses on the other pin
  task automatic wait_for(input int sel, input int maxn, output int n, output int other);
    other = 0;
    for (int i = 1; i <= maxn + 1; i++) begin
      @(posedge clk);
      #1;
      n = i;
      if ((sel == 0 && sys_rst_req_o) || (sel == 1 && irq_o)) other++;
      if ((sel == 0 && irq_o) || (sel == 1 && sys_rst_req_o)) return;
    end
  endtask

  task automatic quiet_for(input int len, output int hits);
    hits = 0;
    for (int i = 0; i < len; i++) begin
      @(posedge clk);
      #1;
      if (irq_o || sys_rst_req_o) hits++;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 check(!irq_o && !sys_rst_req_o, "R1", irq_o + sys_rst_req_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    int n, o, h, exp_i, exp_r;

    // R1, R2: reset values and default timing
    do_reset();
    wait_for(0, DEF_IRQ + 4, n, o);
    check(n == DEF_IRQ && o == 0, "R2 default irq time", n, DEF_IRQ);
    wait_for(1, DEF_RST + 4, n, o);
    check(n == DEF_RST && o == 0, "R2 default reset time", n, DEF_RST);

    // R3, R4, R6, R7: sweep divider and countdown, several grace values
    for (int p = 0; p < 2**PW; p++) begin
      for (int c = 0; c < 2**CW; c++) begin
        for (int k = 0; k < 4; k++) begin
          int d;
          d = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 5 : 7;
          exp_i = (c + 1) * (p + 1);
          exp_r = (d + 1) * (p + 1);
          wr_cfg(c, p, d);
          wait_for(0, exp_i + 2, n, o);
          check(n == exp_i && o == 0, "R3 irq timing", n, exp_i);
          wait_for(1, exp_r + 2, n, o);
          check(n == exp_r && o == 0, "R4 R6 grace timing, single irq pulse", n, exp_r);
          @(posedge clk);
          #1 check(!sys_rst_req_o, "R6 reset pulse width", sys_rst_req_o, 0);
          if (c == 2**CW - 1 && k == 0) begin
            wait_for(0, DEF_IRQ + 2, n, o);
            check(n == DEF_IRQ - 1, "R7 defaults restored", n, DEF_IRQ - 1);
            wait_for(1, DEF_RST + 2, n, o);
            check(n == DEF_RST, "R7 default grace restored", n, DEF_RST);
            @(posedge clk);
            #1;
          end
        end
      end
    end

    // R8: rewrite during grace phase cancels the pending reset
    wr_cfg(2, 1, 7);
    wait_for(0, 10, n, o);
    check(n == 6, "R8 setup irq", n, 6);
    repeat (3) @(posedge clk);
    wr_cfg(3, 0, 2);
    wait_for(0, 10, n, o);
    check(n == 4 && o == 0, "R8 pending cleared, irq again", n, 4);
    wait_for(1, 10, n, o);
    check(n == 3, "R8 new grace value", n, 3);

    // R8: rewrite while counting restarts divider and countdown
    wr_cfg(15, 3, 7);
    repeat (20) @(posedge clk);
    wr_cfg(1, 0, 0);
    wait_for(0, 10, n, o);
    check(n == 2, "R8 restart mid count", n, 2);
    wait_for(1, 10, n, o);

    // R5, R9: disable in power-up state, then restart from stopped
    do_reset();
    dis_pulse();
    quiet_for(200, h);
    check(h == 0, "R5 R9 disabled stays quiet", h, 0);
    wr_cfg(2, 1, 1);
    wait_for(0, 10, n, o);
    check(n == 6, "R8 R9 restart from stopped", n, 6);
    wait_for(1, 10, n, o);
    check(n == 4, "R8 grace after restart", n, 4);

    // R5: disable strobe after a configuration write is ignored
    @(posedge clk);
    #1;
    wr_cfg(3, 1, 1);
    dis_pulse();
    wait_for(0, 12, n, o);
    check(n == 7, "R5 late disable ignored", n, 7);
    dis_pulse();
    wait_for(1, 10, n, o);
    check(n == 3, "R5 disable in grace ignored", n, 3);

    // R7: after a reset request the disable strobe is honoured again
    dis_pulse();
    quiet_for(150, h);
    check(h == 0, "R7 disable accepted after restore", h, 0);

    // R8: configuration write wins over disable in the same cycle
    do_reset();
    @(negedge clk);
    cfg_we = 1'b1;
    dis_we = 1'b1;
    cfg_wdata = {DW'(0), PW'(1), CW'(1)};
    @(posedge clk);
    #1 begin cfg_we = 1'b0; dis_we = 1'b0; end
    wait_for(0, 10, n, o);
    check(n == 4, "R8 priority over disable", n, 4);
    wait_for(1, 10, n, o);
    check(n == 2, "R6 grace zero", n, 2);

    finish_run();
  end
endmodule